// File: doc/BRIEF.md
# External and Pin-Change Interrupt Controller

This block turns pin activity into interrupt requests for a small microcontroller core. It watches one dedicated interrupt pin and a group of pin-change inputs. The dedicated pin has a two-bit sense selector that picks low level, any change, falling edge or rising edge. A per-pin mask chooses which pin-change inputs take part. The detector reads the pin level only, so it does not care about the direction of the pin. Firmware can therefore raise an interrupt by driving a pin that is configured as an output.

Edge and pin-change events set sticky pending flags, and software clears a flag by writing 1. In level mode no flag is latched. The request follows the synchronised pin for as long as it stays low. A request goes to the CPU only when its own enable and the global enable are both set.

A combinational wake output lets a sleep controller leave deep sleep while the I/O clock is stopped. It responds to a low level or to a masked pin change. While the I/O clock is stopped, level requests are held back until the wake sequencer pulses start-up complete. A low level that has gone away by then wakes the device but produces no interrupt.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset both pending flags, both requests and the wake output are 0, with the dedicated pin high and all pin-change inputs low.
- R2: With sense 2'b10, a high-to-low transition on the dedicated pin sets the external flag on the third rising clock edge after the change. A low-to-high transition does not set it.
- R3: With sense 2'b11, a low-to-high transition sets the external flag with the same latency. A high-to-low transition does not set it.
- R4: With sense 2'b01, either transition sets the external flag.
- R5: In the edge modes (2'b01, 2'b10, 2'b11), a transition that occurs while the I/O clock enable is 0 does not set the external flag.
- R6: With sense 2'b00, the external flag is not set. The external request is 1 from the second rising edge after the pin goes low until the second edge after it returns high, provided both enables are set and no start-up wait is pending.
- R7: A toggle on pin-change input i sets the pin-change flag on the third rising edge if mask bit i is 1, whatever the I/O clock enable. If mask bit i is 0, the toggle never sets the flag.
- R8: A 1 on a clear strobe clears its flag at the next edge. When a new event and a clear fall on the same edge, the flag stays set.
- R9: Each request equals its pending condition ANDed with its own enable and the global enable. A flag is still set while its enable is 0.
- R10: The wake output is combinational and does not depend on the I/O clock enable. It is 1 when the external enable is set, sense is 2'b00 and the pin is low. It is also 1 when the pin-change enable is set and either an unsynchronised masked input differs from its last sampled value or the pin-change flag is set. It is also 1 when the external enable and the external flag are both set.
- R11: Once any edge has seen the I/O clock enable at 0, the level request is held off until an edge with the start-up strobe at 1. After that strobe the request is 1 only if the pin is still low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running low-speed clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ioClkEn | input | 1 | 1 while the I/O clock runs; 0 means deep sleep |
| startupDone | input | 1 | One-cycle strobe from the wake sequencer |
| pinExt | input | 1 | Dedicated interrupt pin level |
| pinChg | input | 4 | Pin-change input levels |
| senseCtl | input | 2 | 00 low, 01 any change, 10 falling, 11 rising |
| chgMask | input | 4 | Per-pin contribution mask |
| extEn | input | 1 | External interrupt enable |
| chgEn | input | 1 | Pin-change interrupt enable |
| globalEn | input | 1 | Global interrupt enable |
| clrExtFlag | input | 1 | Write-1 clear of the external flag |
| clrChgFlag | input | 1 | Write-1 clear of the pin-change flag |
| extFlag | output | 1 | External pending flag |
| chgFlag | output | 1 | Pin-change pending flag |
| extReq | output | 1 | External request to the CPU |
| chgReq | output | 1 | Pin-change request to the CPU |
| wakeReq | output | 1 | Asynchronous wake request |

## Verification
The bench sweeps every sense mode against both edge directions, once with the I/O clock running and once with it stopped. A wrong mode decode would latch the wrong edge. Missing clock gating would latch edges while the clock is stopped. The bench also sweeps every mask value against every pin-change input. This exposes masked pins that leak into the flag, and a wake output that waits for the synchroniser instead of reacting at once. The targeted cases are:
- a clear that lands on the same edge as a new event, where a wrong priority loses the event;
- flags that must still set with their enable cleared;
- a level wake that either survives or disappears before start-up completes, where a design without the hold-off would raise an interrupt early or one that is stale.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_t;

  typedef struct packed {
    logic setExt;
    logic clrExt;
    logic setChg;
    logic clrChg;
  } irqStrobes_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_CHG = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pinExt,
  input  logic [NUM_CHG-1:0] pinChg,
  input  logic [NUM_CHG-1:0] chgMask,
  input  irqStrobes_t        strobes,
  output logic               extSync,
  output logic               extRise,
  output logic               extFall,
  output logic               chgHit,
  output logic               chgLive,
  output logic               extFlag,
  output logic               chgFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] extPipe;
  logic                   extPrev;
  logic [NUM_CHG-1:0]     chgPipe [SYNC_STAGES];
  logic [NUM_CHG-1:0]     chgPrev;

  // The dedicated pin idles high; the pin-change inputs are taken as low at reset.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extPipe <= '1;
      extPrev <= 1'b1;
    end else begin
      extPipe <= {extPipe[SYNC_STAGES-2:0], pinExt};
      extPrev <= extPipe[LAST];
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_chgSync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chgPipe[s] <= '0;
      else if (s == 0) chgPipe[s] <= pinChg;
      else chgPipe[s] <= chgPipe[(s == 0) ? 0 : s-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chgPrev <= '0;
    else chgPrev <= chgPipe[LAST];
  end

  assign extSync = extPipe[LAST];
  assign extRise = extSync & ~extPrev;
  assign extFall = ~extSync & extPrev;
  assign chgHit  = |((chgPipe[LAST] ^ chgPrev) & chgMask);
  assign chgLive = |((pinChg ^ chgPrev) & chgMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extFlag <= 1'b0;
      chgFlag <= 1'b0;
    end else begin
      if (strobes.setExt) extFlag <= 1'b1;
      else if (strobes.clrExt) extFlag <= 1'b0;
      if (strobes.setChg) chgFlag <= 1'b1;
      else if (strobes.clrChg) chgFlag <= 1'b0;
    end
  end

  // R8
  clr_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrExt && !strobes.setExt) |=> !extFlag);
  // R8
  clr_chg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.clrChg && !strobes.setChg) |=> !chgFlag);
  // R2
  set_ext_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setExt |=> extFlag);
  // R7
  set_chg_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.setChg |=> chgFlag);
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ioClkEn,
  input  logic        startupDone,
  input  logic        pinExt,
  input  logic [1:0]  senseCtl,
  input  logic        extEn,
  input  logic        chgEn,
  input  logic        globalEn,
  input  logic        clrExtFlag,
  input  logic        clrChgFlag,
  input  logic        extSync,
  input  logic        extRise,
  input  logic        extFall,
  input  logic        chgHit,
  input  logic        chgLive,
  input  logic        extFlag,
  input  logic        chgFlag,
  output irqStrobes_t strobes,
  output logic        extReq,
  output logic        chgReq,
  output logic        wakeReq
);
  senseMode_t mode;
  logic       edgeSeen;
  logic       awaitStart;
  logic       levelMode;

  assign mode      = senseMode_t'(senseCtl);
  assign levelMode = (mode == SENSE_LOW);

  always_comb begin
    unique case (mode)
      SENSE_ANY:  edgeSeen = extRise | extFall;
      SENSE_FALL: edgeSeen = extFall;
      SENSE_RISE: edgeSeen = extRise;
      default:    edgeSeen = 1'b0;
    endcase
  end

  always_comb begin
    strobes.setExt = ioClkEn & edgeSeen;
    strobes.clrExt = clrExtFlag;
    strobes.setChg = chgHit;
    strobes.clrChg = clrChgFlag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) awaitStart <= 1'b0;
    else if (startupDone) awaitStart <= 1'b0;
    else if (!ioClkEn) awaitStart <= 1'b1;
  end

  assign extReq = globalEn & extEn &
                  (levelMode ? (~extSync & ~awaitStart) : extFlag);
  assign chgReq = globalEn & chgEn & chgFlag;
  assign wakeReq = (extEn & levelMode & ~pinExt)
                 | (extEn & extFlag)
                 | (chgEn & (chgLive | chgFlag));

  // R9
  ext_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    extReq |-> (globalEn && extEn));
  // R9
  chg_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    chgReq |-> (globalEn && chgEn && chgFlag));
  // R5
  clk_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ioClkEn && !extFlag) |=> !extFlag);
  // R11
  hold_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (awaitStart && levelMode) |-> !extReq);
  // R6
  level_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (levelMode && !extFlag) |=> !extFlag);
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_CHG = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ioClkEn,
  input  logic               startupDone,
  input  logic               pinExt,
  input  logic [NUM_CHG-1:0] pinChg,
  input  logic [1:0]         senseCtl,
  input  logic [NUM_CHG-1:0] chgMask,
  input  logic               extEn,
  input  logic               chgEn,
  input  logic               globalEn,
  input  logic               clrExtFlag,
  input  logic               clrChgFlag,
  output logic               extFlag,
  output logic               chgFlag,
  output logic               extReq,
  output logic               chgReq,
  output logic               wakeReq
);
  irqStrobes_t strobes;
  logic extSync, extRise, extFall, chgHit, chgLive;

  irq_datapath #(.NUM_CHG(NUM_CHG), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinExt(pinExt), .pinChg(pinChg),
    .chgMask(chgMask), .strobes(strobes), .extSync(extSync),
    .extRise(extRise), .extFall(extFall), .chgHit(chgHit),
    .chgLive(chgLive), .extFlag(extFlag), .chgFlag(chgFlag)
  );

  irq_control u_ctl (
    .clk(clk), .rstN(rstN), .ioClkEn(ioClkEn), .startupDone(startupDone),
    .pinExt(pinExt), .senseCtl(senseCtl), .extEn(extEn), .chgEn(chgEn),
    .globalEn(globalEn), .clrExtFlag(clrExtFlag), .clrChgFlag(clrChgFlag),
    .extSync(extSync), .extRise(extRise), .extFall(extFall),
    .chgHit(chgHit), .chgLive(chgLive), .extFlag(extFlag),
    .chgFlag(chgFlag), .strobes(strobes), .extReq(extReq),
    .chgReq(chgReq), .wakeReq(wakeReq)
  );
endmodule

// File: tb/ext_irq_ctrl_tb.sv
module ext_irq_ctrl_tb;
  logic clk = 0, rstN = 0;
  logic ioClkEn = 1, startupDone = 0, pinExt = 1;
  logic [3:0] pinChg = '0, chgMask = '0;
  logic [1:0] senseCtl = '0;
  logic extEn = 0, chgEn = 0, globalEn = 0, clrExtFlag = 0, clrChgFlag = 0;
  logic extFlag, chgFlag, extReq, chgReq, wakeReq;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ext_irq_ctrl u_dut (
    .clk(clk), .rstN(rstN), .ioClkEn(ioClkEn), .startupDone(startupDone),
    .pinExt(pinExt), .pinChg(pinChg), .senseCtl(senseCtl), .chgMask(chgMask),
    .extEn(extEn), .chgEn(chgEn), .globalEn(globalEn),
    .clrExtFlag(clrExtFlag), .clrChgFlag(clrChgFlag), .extFlag(extFlag),
    .chgFlag(chgFlag), .extReq(extReq), .chgReq(chgReq), .wakeReq(wakeReq)
  );

  task automatic check(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseClrExt();
    clrExtFlag = 1; step(1); clrExtFlag = 0;
  endtask

  task automatic pulseClrChg();
    clrChgFlag = 1; step(1); clrChgFlag = 0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1;
    step(3);
    // R1 reset state
    check("R1 extFlag", extFlag, 0);
    check("R1 chgFlag", chgFlag, 0);
    check("R1 extReq", extReq, 0);
    check("R1 chgReq", chgReq, 0);
    check("R1 wakeReq", wakeReq, 0);

    // R2 R3 R4 R5 sweep: mode x clock enable x direction
    globalEn = 1; extEn = 0;
    for (int m = 0; m < 4; m++) begin
      for (int ioc = 0; ioc < 2; ioc++) begin
        for (int dir = 0; dir < 2; dir++) begin
          logic expFlag;
          ioClkEn = 1; senseCtl = 2'b01; pinExt = (dir == 0);
          startupDone = 1; step(4); startupDone = 0;
          pulseClrExt();
          senseCtl = 2'(m); ioClkEn = ioc[0]; step(1);
          pinExt = ~pinExt;
          step(2);
          check("R2 R3 latency flag early", extFlag, 0);
          step(1);
          expFlag = (ioc == 1) && ((m == 1) || (m == 2 && dir == 0) || (m == 3 && dir == 1));
          if (m == 0) check("R6 no flag in level mode", extFlag, 0);
          else if (ioc == 0) check("R5 edge ignored with clock stopped", extFlag, 0);
          else if (m == 1) check("R4 any change", extFlag, expFlag);
          else if (m == 2) check("R2 falling", extFlag, expFlag);
          else check("R3 rising", extFlag, expFlag);
        end
      end
    end
    ioClkEn = 1; startupDone = 1; step(1); startupDone = 0;
    senseCtl = 2'b01; pinExt = 1; step(4); pulseClrExt();

    // R6 level mode
    senseCtl = 2'b00; extEn = 1; globalEn = 1; step(1);
    pinExt = 0; #1;
    check("R10 level wake immediate", wakeReq, 1);
    step(1);
    check("R6 level req after one edge", extReq, 0);
    step(1);
    check("R6 level req asserted", extReq, 1);
    step(5);
    check("R6 level req held", extReq, 1);
    check("R6 level no flag", extFlag, 0);
    pinExt = 1; step(1);
    check("R6 level req still up", extReq, 1);
    step(1);
    check("R6 level req released", extReq, 0);
    check("R10 level wake released", wakeReq, 0);

    // R11 start-up hold-off, level still low
    ioClkEn = 0; step(2);
    pinExt = 0; step(4);
    check("R11 held off while awaiting", extReq, 0);
    check("R10 wake without clock", wakeReq, 1);
    ioClkEn = 1; startupDone = 1; step(1); startupDone = 0;
    check("R11 taken after start-up", extReq, 1);
    pinExt = 1; step(3);
    // R11 level gone before start-up
    ioClkEn = 0; step(2);
    pinExt = 0; step(3);
    pinExt = 1; #1;
    check("R10 wake drops with level", wakeReq, 0);
    step(3);
    ioClkEn = 1; startupDone = 1; step(1); startupDone = 0;
    check("R11 no interrupt after stale level", extReq, 0);
    step(2);
    check("R11 still none", extReq, 0);

    // R9 enables and R8 set-over-clear
    senseCtl = 2'b10; extEn = 0; step(2);
    pinExt = 0; step(3);
    check("R9 flag sets with enable clear", extFlag, 1);
    check("R9 req gated by enable", extReq, 0);
    extEn = 1; #1;
    check("R9 req with enables", extReq, 1);
    globalEn = 0; #1;
    check("R9 req gated by global", extReq, 0);
    globalEn = 1;
    pulseClrExt();
    check("R8 clear ext", extFlag, 0);
    pinExt = 1; step(3);
    pinExt = 0; step(2);
    pulseClrExt();
    check("R8 set wins over clear", extFlag, 1);
    pulseClrExt();
    check("R8 clear after set", extFlag, 0);
    extEn = 0; pinExt = 1; step(3);

    // R7 R10 mask sweep; clock stopped to show pin change needs none
    chgEn = 1; ioClkEn = 0;
    for (int mk = 0; mk < 16; mk++) begin
      for (int p = 0; p < 4; p++) begin
        logic bitOn;
        bitOn = mk[p];
        chgMask = 4'(mk); step(1);
        pinChg[p] = ~pinChg[p]; #1;
        check("R10 chg wake immediate", wakeReq, bitOn);
        step(3);
        check("R7 chg flag vs mask", chgFlag, bitOn);
        check("R9 chg req", chgReq, bitOn);
        pulseClrChg();
        check("R8 clear chg", chgFlag, 0);
      end
    end
    chgEn = 0; chgMask = 4'hF; step(1);
    pinChg[0] = ~pinChg[0]; step(3);
    check("R9 chg flag with enable clear", chgFlag, 1);
    check("R9 chg req gated", chgReq, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule